// File: doc/BRIEF.md
# Chip-Select Strobe Timing Generator

This block sequences the control strobes of one external memory bank for a single read or write access. It runs on a fast clock at four times the bus clock. Each fast-clock cycle is one quarter of a bus clock, so every strobe edge can fall on a quarter-clock offset. An access starts on a one-cycle request that carries the direction and the bank's option settings. The block latches these settings and then drives five outputs: an address-valid window, a write-data drive window, the chip select, the output enable for reads and the write enable for writes. It also drives a read/write level. A one-cycle completion pulse ends the access.

The bank options are a 2-bit chip-select delay code, a relaxed-timing flag, an early-negate flag and a wait-cycle count. Relaxed timing pushes the chip select and the read/write strobes one bus clock later and doubles the cost of each wait cycle. Under relaxed timing, early negate drops chip select and the strobes well before the address goes invalid. Every output is a flop, loaded from a decode of the next sequencer state, so no output can glitch. Address decoding, bank matching, bursts, external acknowledge and data steering are handled elsewhere.

Top module: `strb_timing_gen`

## Requirements
- R1: After reset, and whenever no access is in progress, cs_o, oe_o, we_o, addr_vld_o, wdata_oe_o and done_o are 0 and rnw_o is 1.
- R2: Let s be the wait count and L the access length in bus clocks. L is 2+s with relaxed timing off. With relaxed timing on, L is 3+2s, or 4+2s when early negate is also set. Quarters are counted as k, where k=0 is the first fast cycle after the edge that accepts start_i. The access then occupies quarters k=0..4L.
- R3: The chip-select delay code is read as follows: code 0 gives 0 quarters, code 2 gives 1 quarter and code 3 gives 2 quarters. With relaxed timing off, cs_o rises at quarter k = 1 + delay.
- R4: Relaxed timing adds 4 quarters (one bus clock) to the chip-select rise point, and also to the oe_o and we_o rise points.
- R5: On a read, oe_o rises 3 quarters after the address, at k=4 (k=8 relaxed). It stays high through the same last quarter as cs_o. we_o stays 0.
- R6: On a write, we_o rises 3 quarters after the address, at k=4 (k=8 relaxed). It stays high through the same last quarter as cs_o. oe_o stays 0.
- R7: addr_vld_o is high for k=1..4L. On a write, wdata_oe_o is high for k=0..4L, one quarter before the address. On a read, wdata_oe_o stays 0.
- R8: cs_o, oe_o and we_o are last high at k=4L-1, one quarter before the address goes invalid. With both relaxed timing and early negate set, they are last high at k=4L-6, a gap of 1.5 bus clocks. Early negate has no effect when relaxed timing is off.
- R9: done_o is high for exactly the one cycle k=4L. A start_i that arrives while an access is in progress is ignored and does not change any output of that access.
- R10: oe_o is never high during a write and we_o is never high during a read.
- R11: rnw_o is 0 for k=0..4L of a write access and 1 at all other times.
- R12: Chip-select delay code 1 is treated exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle access request, accepted only when idle |
| rnw_i | input | 1 | Direction of the request: 1 read, 0 write |
| cs_dly_i | input | 2 | Chip-select delay code |
| relax_i | input | 1 | Relaxed timing option |
| early_i | input | 1 | Early strobe negation option |
| wait_i | input | SCY_W | Wait-cycle count |
| addr_vld_o | output | 1 | Address-valid window |
| wdata_oe_o | output | 1 | Write-data drive window |
| cs_o | output | 1 | Chip select, active high |
| oe_o | output | 1 | Output enable, active high |
| we_o | output | 1 | Write enable, active high |
| rnw_o | output | 1 | Read/write level to the device |
| done_o | output | 1 | Access complete pulse |

## Verification
Assertions check every cycle that the direction exclusivity of oe_o and we_o holds. They also check that strobes sit inside the address window, that write enable only occurs with write data driven, that the completion pulse lasts one cycle, that a start during an access leaves the latched options untouched, and that the quarter counter never passes its final value. The exact quarter on which each edge falls depends on the combination of delay code, relaxed timing, early negate and wait count. Only the bench's sweep over all of these combinations can show those positions, the resulting access length, the idle state between accesses, and the fact that code 1 matches code 0.

// File: rtl/strb_pkg.sv
package strb_pkg;

  typedef struct packed {
    logic [1:0] dly;
    logic       relax;
    logic       early;
    logic       rnw;
  } bank_cfg_t;

  // Length of the access in quarter clocks; the last quarter index equals this value.
  function automatic int unsigned access_quarters(logic relax, logic early, int unsigned wt);
    int unsigned clks;
    if (!relax)     clks = 2 + wt;
    else if (early) clks = 4 + 2 * wt;
    else            clks = 3 + 2 * wt;
    return 4 * clks;
  endfunction

  // Quarter on which chip select first rises (address launches at quarter 1).
  function automatic int unsigned cs_rise_q(logic [1:0] dly, logic relax);
    int unsigned d;
    case (dly)
      2'b10:   d = 1;
      2'b11:   d = 2;
      default: d = 0;
    endcase
    return 1 + d + (relax ? 4 : 0);
  endfunction

  // Quarter on which output or write enable first rises.
  function automatic int unsigned strobe_rise_q(logic relax);
    return 4 + (relax ? 4 : 0);
  endfunction

  // Last quarter in which chip select and strobes are still high.
  function automatic int unsigned strobe_last_q(int unsigned total, logic relax, logic early);
    return (relax && early) ? total - 6 : total - 1;
  endfunction

endpackage

// File: rtl/strb_seq.sv
module strb_seq
  import strb_pkg::*;
#(
  parameter int SCY_W = 4,
  parameter int QW    = SCY_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  bank_cfg_t        cfg_i,
  input  logic [SCY_W-1:0] wait_i,
  output logic             busy_n_o,
  output logic [QW-1:0]    q_n_o,
  output bank_cfg_t        cfg_n_o,
  output logic [SCY_W-1:0] wait_n_o
);

  logic             busy_q;
  logic [QW-1:0]    q_q;
  bank_cfg_t        cfg_q;
  logic [SCY_W-1:0] wait_q;
  logic [QW-1:0]    last_q;
  logic             at_end;
  logic             accept;

  assign last_q = QW'(access_quarters(cfg_q.relax, cfg_q.early, 32'(wait_q)));
  assign at_end = busy_q && (q_q == last_q);
  assign accept = !busy_q && start_i;

  always_comb begin
    busy_n_o = busy_q;
    q_n_o    = q_q;
    cfg_n_o  = cfg_q;
    wait_n_o = wait_q;
    if (accept) begin
      busy_n_o = 1'b1;
      q_n_o    = '0;
      cfg_n_o  = cfg_i;
      wait_n_o = wait_i;
    end else if (at_end) begin
      busy_n_o = 1'b0;
    end else if (busy_q) begin
      q_n_o = q_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      q_q    <= '0;
      cfg_q  <= '{dly: 2'b00, relax: 1'b0, early: 1'b0, rnw: 1'b1};
      wait_q <= '0;
    end else begin
      busy_q <= busy_n_o;
      q_q    <= q_n_o;
      cfg_q  <= cfg_n_o;
      wait_q <= wait_n_o;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !at_end) |=> ($stable(cfg_q) && $stable(wait_q))); // R9
  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (q_q <= last_q)); // R2

endmodule

// File: rtl/strb_decode.sv
module strb_decode
  import strb_pkg::*;
#(
  parameter int SCY_W = 4,
  parameter int QW    = SCY_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_n_i,
  input  logic [QW-1:0]    q_n_i,
  input  bank_cfg_t        cfg_n_i,
  input  logic [SCY_W-1:0] wait_n_i,
  output logic             addr_vld_o,
  output logic             wdata_oe_o,
  output logic             cs_o,
  output logic             oe_o,
  output logic             we_o,
  output logic             rnw_o,
  output logic             done_o
);

  int unsigned qv, total, cs_on, st_on, st_off;
  logic addr_win, data_win, cs_win, st_win, end_hit;

  always_comb begin
    qv       = {{(32-QW){1'b0}}, q_n_i};
    total    = access_quarters(cfg_n_i.relax, cfg_n_i.early, 32'(wait_n_i));
    cs_on    = cs_rise_q(cfg_n_i.dly, cfg_n_i.relax);
    st_on    = strobe_rise_q(cfg_n_i.relax);
    st_off   = strobe_last_q(total, cfg_n_i.relax, cfg_n_i.early);
    addr_win = busy_n_i && (qv >= 1) && (qv <= total);
    data_win = busy_n_i && !cfg_n_i.rnw;
    cs_win   = busy_n_i && (qv >= cs_on) && (qv <= st_off);
    st_win   = busy_n_i && (qv >= st_on) && (qv <= st_off);
    end_hit  = busy_n_i && (qv == total);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_vld_o <= 1'b0;
      wdata_oe_o <= 1'b0;
      cs_o       <= 1'b0;
      oe_o       <= 1'b0;
      we_o       <= 1'b0;
      rnw_o      <= 1'b1;
      done_o     <= 1'b0;
    end else begin
      addr_vld_o <= addr_win;
      wdata_oe_o <= data_win;
      cs_o       <= cs_win;
      oe_o       <= st_win && cfg_n_i.rnw;
      we_o       <= st_win && !cfg_n_i.rnw;
      rnw_o      <= !data_win;
      done_o     <= end_hit;
    end
  end

  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> wdata_oe_o); // R7
  AST_CS_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o || oe_o || we_o) |-> addr_vld_o); // R8

endmodule

// File: rtl/strb_timing_gen.sv
module strb_timing_gen
  import strb_pkg::*;
#(
  parameter int SCY_W = 4,
  localparam int QW   = SCY_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rnw_i,
  input  logic [1:0]       cs_dly_i,
  input  logic             relax_i,
  input  logic             early_i,
  input  logic [SCY_W-1:0] wait_i,
  output logic             addr_vld_o,
  output logic             wdata_oe_o,
  output logic             cs_o,
  output logic             oe_o,
  output logic             we_o,
  output logic             rnw_o,
  output logic             done_o
);

  bank_cfg_t        req_cfg;
  logic             busy_n;
  logic [QW-1:0]    q_n;
  bank_cfg_t        cfg_n;
  logic [SCY_W-1:0] wait_n;

  assign req_cfg = '{dly: cs_dly_i, relax: relax_i, early: early_i, rnw: rnw_i};

  strb_seq #(.SCY_W(SCY_W), .QW(QW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_i    (req_cfg),
    .wait_i   (wait_i),
    .busy_n_o (busy_n),
    .q_n_o    (q_n),
    .cfg_n_o  (cfg_n),
    .wait_n_o (wait_n)
  );

  strb_decode #(.SCY_W(SCY_W), .QW(QW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_n_i   (busy_n),
    .q_n_i      (q_n),
    .cfg_n_i    (cfg_n),
    .wait_n_i   (wait_n),
    .addr_vld_o (addr_vld_o),
    .wdata_oe_o (wdata_oe_o),
    .cs_o       (cs_o),
    .oe_o       (oe_o),
    .we_o       (we_o),
    .rnw_o      (rnw_o),
    .done_o     (done_o)
  );

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> rnw_o); // R10
  AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> !rnw_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (addr_vld_o && !cs_o)); // R8

endmodule

// File: tb/tb_strb_timing_gen.sv
module tb_strb_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SCY_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rnw_i = 1'b1, relax_i = 1'b0, early_i = 1'b0;
  logic [1:0] cs_dly_i = 2'b00;
  logic [SCY_W-1:0] wait_i = '0;
  logic addr_vld_o, wdata_oe_o, cs_o, oe_o, we_o, rnw_o, done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strb_timing_gen #(.SCY_W(SCY_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rnw_i(rnw_i),
    .cs_dly_i(cs_dly_i), .relax_i(relax_i), .early_i(early_i), .wait_i(wait_i),
    .addr_vld_o(addr_vld_o), .wdata_oe_o(wdata_oe_o), .cs_o(cs_o), .oe_o(oe_o),
    .we_o(we_o), .rnw_o(rnw_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, got, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " addr"}, addr_vld_o, 1'b0, -1);
    chk({tag, " wdata"}, wdata_oe_o, 1'b0, -1);
    chk({tag, " cs"}, cs_o, 1'b0, -1);
    chk({tag, " oe"}, oe_o, 1'b0, -1);
    chk({tag, " we"}, we_o, 1'b0, -1);
    chk({tag, " rnw"}, rnw_o, 1'b1, -1);
    chk({tag, " done"}, done_o, 1'b0, -1);
  endtask

  // One access; expected windows follow the requirement text.
  task automatic run_access(input int dly, input bit rlx, input bit erl, input bit rd,
                            input int wt, input bit poke);
    int bus_clks, last, cs_first, st_first, st_last, dly_q;
    if (!rlx)     bus_clks = 2 + wt;
    else if (erl) bus_clks = 4 + 2 * wt;
    else          bus_clks = 3 + 2 * wt;
    last = bus_clks * 4;
    dly_q = (dly == 3) ? 2 : (dly == 2) ? 1 : 0;   // code 1 acts as code 0 (R12)
    cs_first = 1 + dly_q + (rlx ? 4 : 0);
    st_first = 4 + (rlx ? 4 : 0);
    st_last  = (rlx && erl) ? last - 6 : last - 1;
    @(negedge clk);
    start_i = 1'b1; rnw_i = rd; cs_dly_i = 2'(dly); relax_i = rlx; early_i = erl;
    wait_i = SCY_W'(wt);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (poke && k == 2) begin
        start_i = 1'b1; rnw_i = !rd; relax_i = !rlx; wait_i = '0; cs_dly_i = 2'b11;
      end
      if (poke && k == 3) start_i = 1'b0;
      chk("R2/R7 addr_vld", addr_vld_o, (k >= 1), k);
      chk("R7 wdata_oe", wdata_oe_o, !rd, k);
      chk("R3/R4/R8/R12 cs", cs_o, (k >= cs_first && k <= st_last), k);
      chk("R5/R10 oe", oe_o, rd && k >= st_first && k <= st_last, k);
      chk("R6/R10 we", we_o, !rd && k >= st_first && k <= st_last, k);
      chk("R11 rnw", rnw_o, rd, k);
      chk("R2/R9 done", done_o, (k == last), k);
      @(negedge clk);
    end
    chk_idle("R1 after access");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle");
    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++)
          for (int rd = 0; rd < 2; rd++)
            for (int w = 0; w < 16; w++)
              run_access(d, r[0], e[0], rd[0], w, (w % 5) == 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule